// File: doc/BRIEF.md
# UART DMA Request and Completion Controller

This block sits between the two FIFOs of a UART and a DMA engine. For each direction it drives a single-transfer request line and a burst-transfer request line, derived from the FIFO fill count and a programmable trigger level. The receive side asks for service while data is waiting. The transmit side asks for service while there is room. Every request output is registered, so it follows a FIFO level change by one clock.

The block also gathers four events into a raw interrupt status register, each bit with its own mask: receive DMA done, transmit DMA done, end of transmission from the serializer, and receive error. With the stop-on-error option set, a receive error locks the receive requests off until software clears the receive-error status bit. A two-state lock machine tracks this. In state OPEN the requests flow normally. The transition OPEN to HELD is taken on a receive error while stop-on-error is set. In state HELD the receive requests are forced low. The transition HELD to OPEN is taken when the error status is cleared and no new error arrives in the same cycle; if both happen together the machine stays in HELD. In infrared mode both burst lines are held low and only single requests are made.

A small register port configures the block. Address 0 is control: bit 0 enables receive DMA, bit 1 enables transmit DMA, bit 2 is stop-on-error and bit 3 selects infrared mode. Address 1 holds the trigger codes, receive in bits 2:0 and transmit in bits 5:3. Address 2 is the interrupt mask. Address 3 reads the raw status and clears status bits when written with ones. The status and mask bits are laid out as 0 receive done, 1 transmit done, 2 end of transmission, 3 receive error.

Top module: `uart_dma_ctrl`

## Requirements
- R1: The receive single request is high one clock after the receive fill count is nonzero, provided receive DMA (control bit 0) is enabled and the lock is open.
- R2: The receive burst request is high one clock after the receive fill count is at or above the receive trigger level, under the same conditions as R1 and outside infrared mode.
- R3: The transmit single request is high one clock after the transmit fill count is below the FIFO depth (16), provided transmit DMA (control bit 1) is enabled.
- R4: The transmit burst request is high one clock after the transmit fill count is below the transmit trigger level, provided transmit DMA is enabled and infrared mode is off.
- R5: Trigger codes 0, 1, 2, 3 and 4 select 2, 4, 8, 12 and 14 entries. Codes 5 to 7 select 8 entries.
- R6: With its enable bit clear, a direction drives neither of its request lines.
- R7: With infrared mode (control bit 3) set, both burst lines stay low one clock later, while the single lines still work.
- R8: With stop-on-error (control bit 2) set, a receive error forces both receive requests low from the next clock onward.
- R9: The receive lockout stays in force until a 1 is written to status bit 3 at address 3. Clearing any other status bit does not release it.
- R10: A receive-done or transmit-done pulse sets status bit 0 or 1. The irq output is high while any raw status bit and its mask bit are both set.
- R11: Status bit 2 is set when the serializer busy input falls while the transmit fill count is zero. A fall with data still queued sets nothing.
- R12: Writing 1s to address 3 clears the matching status bits. An event that arrives in the same cycle as a clear keeps its bit set.
- R13: After reset all requests, the irq output and every register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 6 | Register read data, combinational |
| rx_level | input | 5 | Receive FIFO fill count (0 to 16) |
| tx_level | input | 5 | Transmit FIFO fill count (0 to 16) |
| rx_err | input | 1 | Receive error flag |
| rx_dma_done | input | 1 | Receive transfer-complete pulse from the DMA engine |
| tx_dma_done | input | 1 | Transmit transfer-complete pulse from the DMA engine |
| ser_busy | input | 1 | Serializer busy shifting a character |
| rx_single_req | output | 1 | Receive single-transfer request |
| rx_burst_req | output | 1 | Receive burst-transfer request |
| tx_single_req | output | 1 | Transmit single-transfer request |
| tx_burst_req | output | 1 | Transmit burst-transfer request |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is the HELD state of the lock machine, together with the writes that must not release it. These are a clear of some other status bit, and a clear of the error bit in the same cycle as a fresh error. Random stimulus reaches HELD only now and then, because errors are rare and a clear must later hit bit 3. A directed sequence therefore enables stop-on-error, injects an error with data waiting, and writes non-releasing clears before the releasing one. A long random run with occasional errors and clear writes then covers the other interleavings against a bench model.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    localparam int unsigned REG_W = 6;
    localparam int unsigned ST_W  = 4;

    // status and mask bit positions
    localparam int unsigned ST_RXDONE = 0;
    localparam int unsigned ST_TXDONE = 1;
    localparam int unsigned ST_EOT    = 2;
    localparam int unsigned ST_RXERR  = 3;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_TRIG = 2'd1,
        RA_MASK = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic infrared;
        logic stop_on_err;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    // trigger code to entry count, scaled by FIFO depth
    function automatic int unsigned trig_entries(input logic [2:0] code,
                                                 input int unsigned depth);
        case (code)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd3:    return (depth * 3) / 4;
            3'd4:    return (depth * 7) / 8;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_dma_regs.sv
module uart_dma_regs
    import uart_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output logic [2:0]       rx_code,
    output logic [2:0]       tx_code,
    output logic [ST_W-1:0]  mask,
    output logic [ST_W-1:0]  clr_vec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            rx_code <= '0;
            tx_code <= '0;
            mask    <= '0;
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                RA_CTRL: ctrl <= ctrl_t'(wr_data[3:0]);
                RA_TRIG: {tx_code, rx_code} <= wr_data;
                RA_MASK: mask <= wr_data[ST_W-1:0];
                RA_STAT: begin end
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        if (wr_en && (reg_addr_e'(wr_addr) == RA_STAT))
            clr_vec = wr_data[ST_W-1:0];
    end

endmodule

// File: rtl/uart_dma_lockout.sv
module uart_dma_lockout
    import uart_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_set,
    input  logic err_clr,
    output logic gate,
    output logic held
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LK_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (err_set) state_d = LK_HELD;
            LK_HELD: if (err_clr && !err_set) state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        held = (state_q == LK_HELD);
        gate = (state_q == LK_OPEN) && !err_set;
    end

    assert_lock_enter_R8: assert property (@(posedge clk) disable iff (rst)
        err_set |=> (state_q == LK_HELD));

    assert_lock_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == LK_HELD && !err_clr) |=> (state_q == LK_HELD));

endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
    import uart_dma_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter bit          IS_RX      = 1'b1,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             gate,
    input  logic             infrared,
    input  logic [2:0]       code,
    input  logic [LVL_W-1:0] level,
    output logic             single_req,
    output logic             burst_req
);

    logic [LVL_W-1:0] trig_lv;
    logic             single_d;
    logic             burst_d;

    assign trig_lv = LVL_W'(trig_entries(code, FIFO_DEPTH));

    generate
        if (IS_RX) begin : g_rx
            assign single_d = (level != '0);
            assign burst_d  = (level >= trig_lv);
        end else begin : g_tx
            assign single_d = (level < LVL_W'(FIFO_DEPTH));
            assign burst_d  = (level < trig_lv);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            single_req <= 1'b0;
            burst_req  <= 1'b0;
        end else begin
            single_req <= enable & gate & single_d;
            burst_req  <= enable & gate & ~infrared & burst_d;
        end
    end

    assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!single_req && !burst_req));

    assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        !gate |=> (!single_req && !burst_req));

endmodule

// File: rtl/uart_dma_status.sv
module uart_dma_status
    import uart_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic [ST_W-1:0] clr_vec,
    input  logic [ST_W-1:0] mask,
    output logic [ST_W-1:0] raw,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) raw <= '0;
        else     raw <= (raw & ~clr_vec) | set_vec;
    end

    assign irq = |(raw & mask);

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        assert_event_sets_R10: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> raw[i]);
        assert_w1c_clears_R12: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !raw[i]);
    end

endmodule

// File: rtl/uart_dma_ctrl.sv
module uart_dma_ctrl
    import uart_dma_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             rx_err,
    input  logic             rx_dma_done,
    input  logic             tx_dma_done,
    input  logic             ser_busy,
    output logic             rx_single_req,
    output logic             rx_burst_req,
    output logic             tx_single_req,
    output logic             tx_burst_req,
    output logic             irq
);

    ctrl_t           ctrl;
    logic [2:0]      rx_code, tx_code;
    logic [ST_W-1:0] mask, clr_vec, set_vec, raw;
    logic            rx_gate, lock_held, lock_set;
    logic            busy_d, eot_pulse;

    uart_dma_regs i_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data,
        .ctrl, .rx_code, .tx_code, .mask, .clr_vec
    );

    assign lock_set = rx_err & ctrl.stop_on_err;

    uart_dma_lockout i_lock (
        .clk, .rst,
        .err_set (lock_set),
        .err_clr (clr_vec[ST_RXERR]),
        .gate    (rx_gate),
        .held    (lock_held)
    );

    uart_dma_req #(.FIFO_DEPTH(FIFO_DEPTH), .IS_RX(1'b1)) i_rx_req (
        .clk, .rst,
        .enable     (ctrl.rx_en),
        .gate       (rx_gate),
        .infrared   (ctrl.infrared),
        .code       (rx_code),
        .level      (rx_level),
        .single_req (rx_single_req),
        .burst_req  (rx_burst_req)
    );

    uart_dma_req #(.FIFO_DEPTH(FIFO_DEPTH), .IS_RX(1'b0)) i_tx_req (
        .clk, .rst,
        .enable     (ctrl.tx_en),
        .gate       (1'b1),
        .infrared   (ctrl.infrared),
        .code       (tx_code),
        .level      (tx_level),
        .single_req (tx_single_req),
        .burst_req  (tx_burst_req)
    );

    always_ff @(posedge clk) begin
        if (rst) busy_d <= 1'b0;
        else     busy_d <= ser_busy;
    end

    assign eot_pulse = busy_d & ~ser_busy & (tx_level == '0);

    always_comb begin
        set_vec            = '0;
        set_vec[ST_RXDONE] = rx_dma_done;
        set_vec[ST_TXDONE] = tx_dma_done;
        set_vec[ST_EOT]    = eot_pulse;
        set_vec[ST_RXERR]  = rx_err;
    end

    uart_dma_status i_status (
        .clk, .rst, .set_vec, .clr_vec, .mask, .raw, .irq
    );

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            RA_CTRL: rd_data = {2'b00, ctrl};
            RA_TRIG: rd_data = {tx_code, rx_code};
            RA_MASK: rd_data = {2'b00, mask};
            RA_STAT: rd_data = {2'b00, raw};
        endcase
    end

    assert_infrared_no_burst_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.infrared |=> (!rx_burst_req && !tx_burst_req));

    assert_held_blocks_rx_R8: assert property (@(posedge clk) disable iff (rst)
        lock_held |=> (!rx_single_req && !rx_burst_req));

    assert_eot_event_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_busy) && tx_level == '0) |=> raw[ST_EOT]);

endmodule

// File: tb/test_uart_dma_ctrl.sv
module test_uart_dma_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [1:0] rd_addr = 2'd3;
    logic [5:0] rd_data;
    logic [4:0] rx_level = '0;
    logic [4:0] tx_level = '0;
    logic       rx_err = 1'b0;
    logic       rx_dma_done = 1'b0;
    logic       tx_dma_done = 1'b0;
    logic       ser_busy = 1'b0;
    logic       rx_single_req, rx_burst_req, tx_single_req, tx_burst_req, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_dma_ctrl i_uart_dma_ctrl (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .rx_level, .tx_level, .rx_err, .rx_dma_done, .tx_dma_done, .ser_busy,
        .rx_single_req, .rx_burst_req, .tx_single_req, .tx_burst_req, .irq
    );

    // ---------------- expected-value functions from the requirements
    function automatic int f_trig(input logic [2:0] code);
        case (code)
            3'd0: return 2;
            3'd1: return 4;
            3'd3: return 12;
            3'd4: return 14;
            default: return 8;
        endcase
    endfunction

    function automatic bit f_rx_single(input logic [3:0] c, input bit gate, input int lvl);
        return c[0] && gate && (lvl != 0);
    endfunction

    function automatic bit f_rx_burst(input logic [3:0] c, input bit gate, input logic [2:0] code, input int lvl);
        return c[0] && gate && !c[3] && (lvl >= f_trig(code));
    endfunction

    function automatic bit f_tx_single(input logic [3:0] c, input int lvl);
        return c[1] && (lvl < 16);
    endfunction

    function automatic bit f_tx_burst(input logic [3:0] c, input logic [2:0] code, input int lvl);
        return c[1] && !c[3] && (lvl < f_trig(code));
    endfunction

    // ---------------- bench model state
    logic [3:0] m_ctrl, m_mask, m_raw;
    logic [5:0] m_trig;
    logic       m_lock, m_busy_d;
    logic       m_rxs, m_rxb, m_txs, m_txb;

    wire [3:0] m_clr      = (wr_en && wr_addr == 2'd3) ? wr_data[3:0] : 4'd0;
    wire       m_lock_set = rx_err & m_ctrl[2];
    wire       m_gate     = !m_lock && !m_lock_set;
    wire       m_eot      = m_busy_d && !ser_busy && (tx_level == 0);
    wire [3:0] m_set      = {rx_err, m_eot, tx_dma_done, rx_dma_done};
    wire       m_irq      = |(m_raw & m_mask);

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl <= '0; m_mask <= '0; m_raw <= '0; m_trig <= '0;
            m_lock <= 1'b0; m_busy_d <= 1'b0;
            m_rxs <= 1'b0; m_rxb <= 1'b0; m_txs <= 1'b0; m_txb <= 1'b0;
        end else begin
            m_rxs    <= f_rx_single(m_ctrl, m_gate, rx_level);
            m_rxb    <= f_rx_burst(m_ctrl, m_gate, m_trig[2:0], rx_level);
            m_txs    <= f_tx_single(m_ctrl, tx_level);
            m_txb    <= f_tx_burst(m_ctrl, m_trig[5:3], tx_level);
            m_raw    <= (m_raw & ~m_clr) | m_set;
            m_lock   <= m_lock_set ? 1'b1 : (m_clr[3] ? 1'b0 : m_lock);
            m_busy_d <= ser_busy;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_ctrl <= wr_data[3:0];
                    2'd1: m_trig <= wr_data;
                    2'd2: m_mask <= wr_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 rx_single", rx_single_req, m_rxs);
            chk("R2 rx_burst",  rx_burst_req,  m_rxb);
            chk("R3 tx_single", tx_single_req, m_txs);
            chk("R4 tx_burst",  tx_burst_req,  m_txb);
            chk("R10 irq",      irq,           m_irq);
            if (rd_addr == 2'd3) chk("R12 status", rd_data, {2'b00, m_raw});
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1F3A5));
        repeat (3) tick();
        // R13: reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1 chk("R13 reg read", rd_data, 0);
        end
        rd_addr = 2'd3;
        chk("R13 requests", {rx_single_req, rx_burst_req, tx_single_req, tx_burst_req, irq}, 0);
        rst = 1'b0;
        tick();

        // R6: both directions disabled with every condition true
        rx_level = 5'd16; tx_level = 5'd0;
        tick(); tick();
        chk("R6 disabled", {rx_single_req, rx_burst_req, tx_single_req, tx_burst_req}, 0);

        // R5: each trigger code at its edge
        wr(2'd0, 6'b000011);
        for (int c = 0; c < 8; c++) begin
            wr(2'd1, {3'(c), 3'(c)});
            rx_level = 5'(f_trig(3'(c)) - 1); tx_level = 5'(f_trig(3'(c)));
            tick();
            chk("R5 rx below trigger", rx_burst_req, 0);
            chk("R5 tx at trigger", tx_burst_req, 0);
            rx_level = 5'(f_trig(3'(c))); tx_level = 5'(f_trig(3'(c)) - 1);
            tick();
            chk("R5 rx at trigger", rx_burst_req, 1);
            chk("R5 tx below trigger", tx_burst_req, 1);
        end

        // R7: infrared suppresses bursts only
        wr(2'd0, 6'b001011);
        rx_level = 5'd16; tx_level = 5'd0;
        tick();
        chk("R7 bursts low", {rx_burst_req, tx_burst_req}, 0);
        chk("R7 singles high", {rx_single_req, tx_single_req}, 3);

        // R8 / R9: error lockout
        wr(2'd0, 6'b000101);
        wr(2'd3, 6'b001111);
        rx_level = 5'd9;
        tick();
        chk("R8 before error", rx_single_req, 1);
        rx_err = 1'b1;
        tick();
        rx_err = 1'b0;
        chk("R8 locked single", rx_single_req, 0);
        chk("R8 locked burst", rx_burst_req, 0);
        repeat (3) tick();
        chk("R9 still locked", rx_single_req, 0);
        wr(2'd3, 6'b000111);
        tick();
        chk("R9 other clear keeps lock", rx_single_req, 0);
        // clear together with a new error: lock stays
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 6'b001000; rx_err = 1'b1;
        tick();
        wr_en = 1'b0; rx_err = 1'b0;
        tick();
        chk("R9 clear with new error", rx_single_req, 0);
        wr(2'd3, 6'b001000);
        tick();
        chk("R9 released", rx_single_req, 1);

        // R10: done status and mask
        wr(2'd2, 6'b000000);
        wr(2'd3, 6'b001111);
        @(negedge clk); tx_dma_done = 1'b1;
        tick(); tx_dma_done = 1'b0;
        chk("R10 tx done raw", rd_data[1], 1);
        chk("R10 masked off", irq, 0);
        wr(2'd2, 6'b000010);
        chk("R10 mask on", irq, 1);

        // R12: event beats simultaneous clear
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 6'b000001; rx_dma_done = 1'b1;
        tick();
        wr_en = 1'b0; rx_dma_done = 1'b0;
        chk("R12 set wins", rd_data[0], 1);
        wr(2'd3, 6'b000001);
        chk("R12 cleared", rd_data[0], 0);

        // R11: end of transmission
        tx_level = 5'd3; ser_busy = 1'b1;
        tick(); ser_busy = 1'b0;
        tick();
        chk("R11 no eot with data", rd_data[2], 0);
        tx_level = 5'd0; ser_busy = 1'b1;
        tick(); ser_busy = 1'b0;
        tick();
        chk("R11 eot set", rd_data[2], 1);
        wr(2'd2, 6'b000100);
        chk("R11 eot irq", irq, 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rx_level    = 5'($urandom_range(0, 16));
            tx_level    = 5'($urandom_range(0, 16));
            rx_err      = ($urandom_range(0, 39) == 0);
            rx_dma_done = ($urandom_range(0, 7) == 0);
            tx_dma_done = ($urandom_range(0, 7) == 0);
            ser_busy    = 1'($urandom_range(0, 1));
            wr_en       = ($urandom_range(0, 5) == 0);
            wr_addr     = 2'($urandom_range(0, 3));
            wr_data     = 6'($urandom_range(0, 63));
        end
        @(negedge clk);
        wr_en = 1'b0; rx_err = 1'b0; rx_dma_done = 1'b0; tx_dma_done = 1'b0;
        tick(); tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule